// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a single-channel serial DAC. A host sends 24-bit command frames over three wires: an active-low frame select, a serial clock and a data line. Bits are taken on the falling edge of the serial clock, most significant bit first. When the 24th bit of a frame arrives, the block loads the DAC code register and the two-bit operating-mode register in one step. If frame select rises before that bit, the partial frame is thrown away and both registers keep their values.

The three serial inputs pass through two-flop synchronisers and their edges are found in the system clock domain. The system clock must therefore run at least four times faster than the serial clock. The mode field picks normal drive or one of three power-down output terminations. The stored code survives every mode change. The resolution parameter selects a 16-bit or a 12-bit code. In both cases the data field is left-aligned in the frame. One-cycle `update_o` and `frame_err_o` pulses mark committed and aborted frames.

Top module: `sdac_cmd_rx`

## Requirements
- R1: A frame is 24 bits, sent MSB first. Frame bit 23 is the first bit sent and bit 0 is the last. Bits 23..18 have no effect. Bits 17..16 are the mode field. Bits 15..0 are the left-aligned data field.
- R2: A bit is taken only on a falling serial-clock edge while frame select is low and a frame is open. Serial-clock activity while select is high changes no output.
- R3: On the 24th falling edge of a frame, `dac_code_o` and `mode_o` both take their new values in the same cycle, and `update_o` is high for exactly that cycle.
- R4: `dac_code_o` and `mode_o` change only in a cycle in which `update_o` is high.
- R5: If frame select rises before the 24th falling edge, the outputs keep their values and `frame_err_o` pulses for one cycle. The next frame is then decoded from its own bits only.
- R6: The mode field gives the termination. 00 is normal drive: `term_sel_o`=000 and `pwr_down_o`=0. 01 is the 1 kΩ to ground: `term_sel_o`=001. 10 is the 100 kΩ to ground: `term_sel_o`=010. 11 is high impedance: `term_sel_o`=100. `pwr_down_o`=1 for every mode other than 00.
- R7: A change of mode never clears or alters the stored code. `dac_code_o` always shows the data of the last committed frame, through power-down and after the return to mode 00.
- R8: Falling edges after the 24th in the same select-low period are ignored. The bit count stays at 24, no second commit occurs, and the later select rise raises no error.
- R9: After reset, `dac_code_o` is 0, `mode_o` is 00, `pwr_down_o` is 0, `term_sel_o` is 000, and both pulses are low.
- R10: With `RES_BITS`=12, `dac_code_o` holds frame bits 15..4 and frame bits 3..0 have no effect. With `RES_BITS`=16 it holds frame bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | RES_BITS | Stored DAC code |
| mode_o | output | 2 | Stored operating mode |
| pwr_down_o | output | 1 | High in any power-down mode |
| term_sel_o | output | 3 | One-hot termination select (1k, 100k, high-Z) |
| update_o | output | 1 | One-cycle pulse when a frame commits |
| frame_err_o | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
On every cycle, the assertions check the following. The termination select is one-hot or zero and matches the power-down flag. The code and mode move only with an update pulse. The bit count never passes 24, and it reaches 24 after a commit. An abort clears the count. The two pulses never coincide and last one cycle. Only the bench scenarios can show the rest: that the right bits land in the code at both resolutions, that don't-care and trailing bits are ignored, that the stored code is kept across power-down, and that an aborted frame leaves nothing behind for the next one.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;

  localparam int FRAME_BITS = 24;
  localparam int MODE_HI    = 17;
  localparam int MODE_LO    = 16;
  localparam int DATA_MSB   = 15;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_1K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_HIZ  = 2'b11
  } dac_mode_e;

  // Left-aligned 16-bit data field of a frame.
  function automatic logic [15:0] frame_payload(input logic [FRAME_BITS-1:0] f);
    return f[DATA_MSB:0];
  endfunction

  // Mode field of a frame.
  function automatic logic [1:0] frame_mode(input logic [FRAME_BITS-1:0] f);
    return f[MODE_HI:MODE_LO];
  endfunction

  // One-hot termination: bit0 = 1k, bit1 = 100k, bit2 = high-Z.
  function automatic logic [2:0] term_decode(input logic [1:0] m);
    logic [2:0] t;
    case (m)
      MODE_PD_1K:   t = 3'b001;
      MODE_PD_100K: t = 3'b010;
      MODE_PD_HIZ:  t = 3'b100;
      default:      t = 3'b000;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sdac_front.sv
`timescale 1ns/1ps
module sdac_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sel_lvl,
  output logic sel_fall,
  output logic sel_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  localparam int W = 3;
  localparam logic [W-1:0] RST_VAL = 3'b100;

  logic [W-1:0] stage [STAGES];
  logic [1:0]   prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= {sel_n_i, sclk_i, sdi_i};
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL[2:1];
    else        prev_q <= stage[STAGES-1][2:1];
  end

  assign sel_lvl   = stage[STAGES-1][2];
  assign sdi_s     = stage[STAGES-1][0];
  assign sel_fall  = prev_q[1] & ~stage[STAGES-1][2];
  assign sel_rise  = ~prev_q[1] & stage[STAGES-1][2];
  assign sclk_fall = prev_q[0] & ~stage[STAGES-1][1];
endmodule

// File: rtl/sdac_frame_shift.sv
`timescale 1ns/1ps
module sdac_frame_shift #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_lvl,
  input  logic                  sel_fall,
  input  logic                  sel_rise,
  input  logic                  sclk_fall,
  input  logic                  sdi_s,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  commit,
  output logic                  abort,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  err_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  active_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  shift_en;

  assign shift_en   = active_q & ~sel_lvl & sclk_fall & (cnt_q < FULL);
  assign frame_word = {sh_q[FRAME_BITS-2:0], sdi_s};
  assign commit     = shift_en & (cnt_q == LAST);
  assign abort      = sel_rise & active_q & (cnt_q < FULL);
  assign bit_cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= abort;
      if (sel_fall) begin
        active_q <= 1'b1;
        sh_q     <= '0;
        cnt_q    <= '0;
      end else if (sel_rise) begin
        active_q <= 1'b0;
        sh_q     <= '0;
        cnt_q    <= '0;
      end else if (shift_en) begin
        sh_q  <= frame_word;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdac_out_regs.sv
`timescale 1ns/1ps
module sdac_out_regs
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [RES_BITS-1:0]   code_q,
  output logic [1:0]            mode_q,
  output logic                  pd,
  output logic [2:0]            term,
  output logic                  upd_q
);
  logic [15:0] payload;
  logic        unused_frame;

  assign payload      = frame_payload(frame_word);
  assign unused_frame = ^frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= MODE_RUN;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit;
      if (commit) begin
        code_q <= payload[15 -: RES_BITS];
        mode_q <= frame_mode(frame_word);
      end
    end
  end

  assign pd   = (mode_q != MODE_RUN);
  assign term = term_decode(mode_q);
endmodule

// File: rtl/sdac_cmd_rx.sv
`timescale 1ns/1ps
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [1:0]          mode_o,
  output logic                pwr_down_o,
  output logic [2:0]          term_sel_o,
  output logic                update_o,
  output logic                frame_err_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  sel_lvl_w, sel_fall_w, sel_rise_w, sclk_fall_w, sdi_w;
  logic [CNT_W-1:0]      bit_cnt_w;
  logic                  commit_w, abort_w;
  logic [FRAME_BITS-1:0] frame_w;

  sdac_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .sel_n_i(sel_n_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sel_lvl(sel_lvl_w), .sel_fall(sel_fall_w), .sel_rise(sel_rise_w),
    .sclk_fall(sclk_fall_w), .sdi_s(sdi_w)
  );

  sdac_frame_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(sel_lvl_w), .sel_fall(sel_fall_w), .sel_rise(sel_rise_w),
    .sclk_fall(sclk_fall_w), .sdi_s(sdi_w),
    .bit_cnt(bit_cnt_w), .commit(commit_w), .abort(abort_w),
    .frame_word(frame_w), .err_q(frame_err_o)
  );

  sdac_out_regs #(.RES_BITS(RES_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(commit_w), .frame_word(frame_w),
    .code_q(dac_code_o), .mode_q(mode_o),
    .pd(pwr_down_o), .term(term_sel_o), .upd_q(update_o)
  );
endmodule

// File: rtl/sdac_cmd_rx_chk.sv
`timescale 1ns/1ps
module sdac_cmd_rx_chk #(
  parameter int RES_BITS = 16,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    bit_cnt,
  input logic                commit,
  input logic                abort,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [1:0]          mode_o,
  input logic                pwr_down_o,
  input logic [2:0]          term_sel_o,
  input logic                update_o,
  input logic                frame_err_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(24);

  assert_term_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_sel_o));

  assert_pd_matches_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_o == (term_sel_o != 3'b000));

  assert_regs_move_with_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> ($stable(dac_code_o) && $stable(mode_o)));

  assert_commit_fills_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (bit_cnt == FULL) && update_o);

  assert_count_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (bit_cnt == '0) && frame_err_o);

  assert_no_pulse_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(update_o && frame_err_o));

  assert_update_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bit_cnt(bit_cnt_w), .commit(commit_w), .abort(abort_w),
  .dac_code_o(dac_code_o), .mode_o(mode_o), .pwr_down_o(pwr_down_o),
  .term_sel_o(term_sel_o), .update_o(update_o), .frame_err_o(frame_err_o)
);

// File: tb/sdac_cmd_rx_bench.sv
`timescale 1ns/1ps
module sdac_cmd_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;

  logic [15:0] code16;
  logic [11:0] code12;
  logic [1:0]  mode16, mode12;
  logic        pd16, pd12, upd16, upd12, err16, err12;
  logic [2:0]  term16, term12;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int n_upd16 = 0, n_err16 = 0, n_upd12 = 0, n_err12 = 0;

  logic [15:0] m_data = '0;
  logic [1:0]  m_mode = 2'b00;
  int          m_upd = 0, m_err = 0;

  always #10 clk = ~clk;

  sdac_cmd_rx #(.RES_BITS(16)) u_sdac_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code16), .mode_o(mode16), .pwr_down_o(pd16),
    .term_sel_o(term16), .update_o(upd16), .frame_err_o(err16)
  );

  sdac_cmd_rx #(.RES_BITS(12)) u_sdac_cmd_rx_12 (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code12), .mode_o(mode12), .pwr_down_o(pd12),
    .term_sel_o(term12), .update_o(upd12), .frame_err_o(err12)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd16) n_upd16++;
      if (err16) n_err16++;
      if (upd12) n_upd12++;
      if (err12) n_err12++;
    end
  end

  function automatic logic [2:0] exp_term(input logic [1:0] m);
    if (m == 2'b00) return 3'b000;
    return 3'b001 << (m - 2'd1);
  endfunction

  function automatic logic [11:0] exp_code12(input logic [15:0] d);
    return d >> 4;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "code16", 32'(code16), 32'(m_data));
    chk(req, "code12", 32'(code12), 32'(exp_code12(m_data)));
    chk(req, "mode", 32'({mode16, mode12}), 32'({m_mode, m_mode}));
    chk(req, "pd", 32'({pd16, pd12}), 32'({2{m_mode != 2'b00}}));
    chk(req, "term", 32'({term16, term12}), 32'({exp_term(m_mode), exp_term(m_mode)}));
    chk(req, "updates", 32'({n_upd16[15:0], n_upd12[15:0]}), 32'({m_upd[15:0], m_upd[15:0]}));
    chk(req, "errors", 32'({n_err16[15:0], n_err12[15:0]}), 32'({m_err[15:0], m_err[15:0]}));
  endtask

  // Sends nbits serial bits in one select-low period; fewer than 24 aborts.
  task automatic send(input logic [23:0] w, input int nbits);
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      sdi  = (k < 24) ? w[23-k] : 1'($urandom % 2);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (10) @(negedge clk);
    if (nbits < 24) m_err++;
    else begin
      m_upd++;
      m_data = w[15:0];
      m_mode = w[17:16];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R9");
    chk("R9", "pulses", 32'({upd16, err16, upd12, err12}), 32'd0);

    send(24'hFC_A5C3, 24);           // don't-care bits all ones
    check_state("R1");
    send(24'h00_ABCF, 24);           // low nibble must not reach 12-bit code
    check_state("R10");
    check_state("R3");

    send(24'h03_1234, 10);           // early select rise
    check_state("R5");
    send(24'h00_4321, 0);            // select pulse with no bits
    check_state("R5");
    send(24'h00_4321, 24);           // clean frame after aborts
    check_state("R5");

    for (int k = 0; k < 10; k++) begin   // clock toggles with select high
      sdi = 1'($urandom % 2);
      sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check_state("R2");
    send(24'h00_8001, 24);
    check_state("R2");

    send(24'h00_7777, 31);           // trailing edges ignored
    check_state("R8");

    send(24'h01_1357, 24);
    check_state("R6");
    send(24'h02_1357, 24);
    check_state("R6");
    send(24'h03_1357, 24);
    check_state("R7");
    send(24'h00_1357, 24);
    check_state("R7");

    for (int it = 0; it < 60; it++) begin
      logic [23:0] w;
      int r, nb;
      w  = 24'($urandom);
      r  = int'($urandom % 8);
      nb = (r == 0) ? int'($urandom % 24) : (r == 1) ? 24 + int'($urandom % 6) : 24;
      send(w, nb);
      check_state("R4");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule